// File: doc/BRIEF.md
# Synchronous-Write Single-Port LUT RAM

This block is a small 16-word by 4-bit memory of the kind built from a logic cell's lookup tables. The write side is synchronous. The write enable, a second write-port enable, the address and the write data are all sampled on one edge of a RAM clock. A write takes place only when both enables were high on that edge. The read side has no register: the read data follows the selected address through combinational logic. A downstream register samples the read data on the rising edge of the system clock, so a consumer can take either the raw read data or a registered copy.

The RAM clock is the system clock. A static polarity input can invert it.

- **Non-inverted polarity:** the RAM samples on the rising edge and a single address input serves both the read and the write. Each cycle therefore does either a read or a write.
- **Inverted polarity:** the write is captured on the falling edge, half a cycle before the output register samples. An address selector feeds the read path from a separate read-address input, so one write and one read can complete within the same cycle.

Top module: `lutram_sync_sp`

## Requirements
- R1: The array holds 16 independent 4-bit words, selected by a 4-bit address. After every location has been written with a distinct value, each one reads back its own value.
- R2: A location changes only when `we` and `wpe` are both 1 at the RAM clock edge. The three other enable combinations leave the read data at that address unchanged.
- R3: The write address and write data are taken as they stand at the RAM clock edge. Changing them after that edge, with the enables low, does not alter what was stored.
- R4: `rdata` follows a change of the read address within the same clock phase, without waiting for any clock edge.
- R5: With `ram_clk_inv` = 0, the RAM samples on the rising edge of `clk` and the read address is `addr`. The `rd_addr` input has no effect on `rdata`.
- R6: With `ram_clk_inv` = 1, the RAM samples on the falling edge of `clk` and the read address is `rd_addr`. A write presented after a rising edge is stored by the following falling edge. A read in that same cycle reaches `rdata_q` at the next rising edge, including a read of the location just written.
- R7: A read of the location being written returns the old word before the RAM clock edge and the new word after it.
- R8: `rdata_q` takes the value of `rdata` on every rising edge of `clk`. It is cleared to 0 while `rst_n` is low. The reset does not define the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the RAM clock is derived from it |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| ram_clk_inv | input | 1 | Static polarity select: 0 = RAM samples on the rising edge, 1 = on the falling edge |
| we | input | 1 | Write enable, sampled on the RAM clock |
| wpe | input | 1 | Write-port enable, sampled on the RAM clock |
| addr | input | 4 | Write address; also the read address when `ram_clk_inv` = 0 |
| wdata | input | 4 | Write data, sampled on the RAM clock |
| rd_addr | input | 4 | Read address used when `ram_clk_inv` = 1 |
| rdata | output | 4 | Combinational read data |
| rdata_q | output | 4 | Read data registered on the rising edge of `clk` |

## Verification
The assertions check the following on every rising edge:
- the output register always carries the previous cycle's read data, and is zero under reset;
- in non-inverted mode, a gated-off cycle with a steady address leaves the read data unchanged;
- in non-inverted mode, an enabled write shows its data at the same address one edge later.

The falling-edge capture in inverted mode, the return of the old word before the write edge, the immunity to address and data changes after the edge, and the independence of all sixteen locations can only be shown by the bench's scenarios. The bench runs these against its own reference model under both polarities.

// File: rtl/lutram_pkg.sv
package lutram_pkg;

    // Address width and data width used by default across the block.
    parameter int unsigned LR_AW = 4;
    parameter int unsigned LR_DW = 4;

    // Static phase relation between the RAM clock and the register clock.
    typedef enum logic {
        PH_SAME  = 1'b0,
        PH_SPLIT = 1'b1
    } phase_mode_e;

endpackage

// File: rtl/lutram_clk_sel.sv
module lutram_clk_sel (
    input  logic clk,
    input  logic inv,
    output logic ram_clk
);
    // A static select, so the XOR acts as a polarity switch rather than a gate.
    assign ram_clk = clk ^ inv;
endmodule

// File: rtl/lutram_rd_mux.sv
module lutram_rd_mux
    import lutram_pkg::*;
#(
    parameter int unsigned AW = LR_AW
) (
    input  phase_mode_e   mode,
    input  logic [AW-1:0] shared_addr,
    input  logic [AW-1:0] read_addr,
    output logic [AW-1:0] rd_idx
);
    // Same phase: one address serves both the read and the write.
    // Split phase: the write address is captured at the falling edge, so the
    // read path is free to take its own address for the rest of the cycle.
    always_comb begin
        unique case (mode)
            PH_SPLIT: rd_idx = read_addr;
            default:  rd_idx = shared_addr;
        endcase
    end
endmodule

// File: rtl/lutram_store.sv
module lutram_store #(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 4
) (
    input  logic          ram_clk,
    input  logic          we,
    input  logic          wpe,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << AW;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
    } store_t;

    store_t st_d, st_q;

    // Both enables, the address and the data are sampled together on the RAM
    // edge. Their AND is the write strobe for that edge.
    always_comb begin
        st_d = st_q;
        if (we && wpe) begin
            st_d.mem[wr_addr] = wr_data;
        end
    end

    // The contents have no reset: their state after power-up is undefined.
    always_ff @(posedge ram_clk) begin
        st_q <= st_d;
    end

    // The read path is unregistered.
    assign rd_data = st_q.mem[rd_idx];
endmodule

// File: rtl/lutram_out_reg.sv
module lutram_out_reg #(
    parameter int unsigned DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    typedef struct packed {
        logic [DW-1:0] data;
    } oreg_t;

    oreg_t or_d, or_q;

    always_comb begin
        or_d      = or_q;
        or_d.data = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            or_q <= '0;
        end else begin
            or_q <= or_d;
        end
    end

    assign dout = or_q.data;
endmodule

// File: rtl/lutram_sync_sp.sv
module lutram_sync_sp
    import lutram_pkg::*;
#(
    parameter int unsigned AW = LR_AW,
    parameter int unsigned DW = LR_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ram_clk_inv,
    input  logic          we,
    input  logic          wpe,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] rdata_q
);
    logic          ram_clk;
    logic [AW-1:0] rd_idx;
    phase_mode_e   mode;

    assign mode = phase_mode_e'(ram_clk_inv);

    lutram_clk_sel u_clk (
        .clk     (clk),
        .inv     (ram_clk_inv),
        .ram_clk (ram_clk)
    );

    lutram_rd_mux #(.AW(AW)) u_mux (
        .mode        (mode),
        .shared_addr (addr),
        .read_addr   (rd_addr),
        .rd_idx      (rd_idx)
    );

    lutram_store #(.AW(AW), .DW(DW)) u_store (
        .ram_clk (ram_clk),
        .we      (we),
        .wpe     (wpe),
        .wr_addr (addr),
        .wr_data (wdata),
        .rd_idx  (rd_idx),
        .rd_data (rdata)
    );

    lutram_out_reg #(.DW(DW)) u_oreg (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rdata),
        .dout  (rdata_q)
    );
endmodule

// File: rtl/lutram_sync_sp_chk.sv
module lutram_sync_sp_chk #(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ram_clk_inv,
    input logic          we,
    input logic          wpe,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic [DW-1:0] rdata,
    input logic [DW-1:0] rdata_q
);
    // R8: the output register is cleared while reset is held
    p_oreg_reset_r8: assert property (@(posedge clk)
        !rst_n |-> rdata_q == '0);

    // R8: the output register carries the previous cycle's read data
    p_oreg_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> rdata_q === $past(rdata));

    // R2 / R5: same-phase mode, no write, steady address => read data steady
    p_gated_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_clk_inv && !(we && wpe) && !$isunknown(rdata))
        |=> (addr != $past(addr)) || (rdata == $past(rdata)));

    // R3: same-phase mode, an enabled write is visible one edge later
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_clk_inv && we && wpe)
        |=> (addr != $past(addr)) || (rdata == $past(wdata)));
endmodule

bind lutram_sync_sp lutram_sync_sp_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ram_clk_inv (ram_clk_inv),
    .we          (we),
    .wpe         (wpe),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .rdata_q     (rdata_q)
);

// File: tb/sim_lutram_sync_sp.sv
`timescale 1ns/1ps
module sim_lutram_sync_sp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       ram_clk_inv = 1'b0;
    logic       we = 1'b0, wpe = 1'b0;
    logic [3:0] addr = '0, wdata = '0, rd_addr = '0;
    logic [3:0] rdata, rdata_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [3:0] model [16];

    typedef struct {
        bit         reg_out;
        logic [3:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    lutram_sync_sp u0 (
        .clk(clk), .rst_n(rst_n), .ram_clk_inv(ram_clk_inv),
        .we(we), .wpe(wpe), .addr(addr), .wdata(wdata),
        .rd_addr(rd_addr), .rdata(rdata), .rdata_q(rdata_q)
    );

    always #2 clk = ~clk;

    // Monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            item_t it;
            logic [3:0] act;
            wait (sb_q.size() != 0);
            it  = sb_q.pop_front();
            act = it.reg_out ? rdata_q : rdata;
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: %s got %h expected %h", it.tag,
                         it.reg_out ? "rdata_q" : "rdata", act, it.exp);
            end
        end
    end

    task automatic expect_val(input bit reg_out, input string tag, input logic [3:0] exp);
        sb_q.push_back('{reg_out, exp, tag});
        wait (sb_q.size() == 0);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic w, input logic p, input logic [3:0] a,
                         input logic [3:0] d, input logic [3:0] ra);
        we = w; wpe = p; addr = a; wdata = d; rd_addr = ra;
    endtask

    initial begin
        #1 rst_n = 1'b0;
        tick(); tick(); tick();
        expect_val(1'b1, "R8", 4'h0);
        rst_n = 1'b1;

        // ---- same-phase mode: fill every location ----
        for (int i = 0; i < 16; i++) begin
            drive(1, 1, 4'(i), 4'(i * 5 + 3), 4'(~i));
            tick();
            model[i] = 4'(i * 5 + 3);
        end
        drive(0, 0, 0, 0, 0);

        // R1: read back all locations, and their registered copies (R8)
        for (int i = 0; i < 16; i++) begin
            drive(0, 0, 4'(i), 4'h0, 4'(i ^ 15));
            #1;
            expect_val(1'b0, "R1", model[i]);
            tick();
            expect_val(1'b1, "R8", model[i]);
        end

        // R5: rd_addr has no effect in same-phase mode
        drive(0, 0, 4'd3, 4'h0, 4'd10);
        #1 expect_val(1'b0, "R5", model[3]);
        rd_addr = 4'd11;
        #0.5 expect_val(1'b0, "R5", model[3]);
        tick();

        // R4: the read follows an address change without a clock edge
        drive(0, 0, 4'd6, 4'h0, 4'd0);
        #0.5 expect_val(1'b0, "R4", model[6]);
        addr = 4'd7;
        #0.5 expect_val(1'b0, "R4", model[7]);
        tick();

        // R2 / R7: all four enable combinations at location 5
        for (int k = 0; k < 4; k++) begin
            logic [3:0] nd;
            nd = ~model[5];
            drive(k[1], k[0], 4'd5, nd, 4'd0);
            #1 expect_val(1'b0, (k == 3) ? "R7" : "R2", model[5]);
            tick();
            drive(0, 0, 4'd5, nd, 4'd0);
            if (k == 3) model[5] = nd;
            expect_val(1'b0, (k == 3) ? "R7" : "R2", model[5]);
        end

        // R3: changes after the edge do not alter the stored word
        drive(1, 1, 4'd9, ~model[9], 4'd0);
        tick();
        model[9] = ~model[9];
        drive(0, 0, 4'd2, model[9] ^ 4'h5, 4'd0);
        #0.5 addr = 4'd9;
        #0.5 expect_val(1'b0, "R3", model[9]);
        tick();

        // ---- inverted polarity: reselect under reset ----
        rst_n = 1'b0;
        ram_clk_inv = 1'b1;
        drive(0, 0, 0, 0, 0);
        tick(); tick();
        expect_val(1'b1, "R8", 4'h0);
        rst_n = 1'b1;
        tick();

        for (int i = 0; i < 16; i++) begin
            drive(1, 1, 4'(i), 4'(i ^ 9), 4'd0);
            tick();
            model[i] = 4'(i ^ 9);
        end

        // R6 / R7: write and read the same location within one cycle
        for (int i = 0; i < 16; i++) begin
            logic [3:0] nd;
            nd = model[i] ^ 4'h6;
            drive(1, 1, 4'(i), nd, 4'(i));
            #0.5 expect_val(1'b0, "R7", model[i]);
            #1   expect_val(1'b0, "R6", nd);
            model[i] = nd;
            drive(0, 0, 4'(i), nd, 4'(i));
            tick();
            expect_val(1'b1, "R6", nd);
        end

        // R6: read of another location while writing, seen at rdata_q
        drive(1, 1, 4'd3, ~model[3], 4'd12);
        tick();
        model[3] = ~model[3];
        expect_val(1'b1, "R6", model[12]);
        drive(0, 0, 4'd3, 4'h0, 4'd3);
        #0.5 expect_val(1'b0, "R6", model[3]);
        tick();

        // R2: gating still applies on the falling-edge capture
        drive(1, 0, 4'd4, ~model[4], 4'd4);
        tick();
        drive(0, 0, 4'd4, 4'h0, 4'd4);
        expect_val(1'b0, "R2", model[4]);

        tick();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #80000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule